// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block arbitrates among a parameterized number of level-sensitive interrupt request lines for a simple in-order CPU. Each line is qualified by its own enable bit and by one global enable. A per-line priority bit places the line in the high level (1) or the low level (0). Qualified requests are captured into a pending register on every clock. A fixed-order arbiter then decodes the pending register, and the lowest index wins within a level.

The controller tracks the routines currently in service in a two-bit register, one bit per level. This lets a high-level request preempt a low-level routine, while nothing can preempt a high-level routine. When it decides to vector, it raises a call request carrying the winning index. The request is held for a fixed number of cycles, and a one-cycle call-taken pulse closes it. After the CPU signals a return from interrupt, no new call is issued until the CPU reports one completed instruction boundary. The CPU pipeline and the vector table sit outside the block; the CPU only supplies the return and instruction-boundary strobes.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `call_req`, `call_taken` and `in_svc` are all zero.
- R2: A qualified request that is present at clock edge k, on an idle controller, raises `call_req` after edge k+1 and not after edge k. This is one cycle of detection.
- R3: `call_req` stays high for exactly CALL_CYC cycles (default 4). `call_taken` is high only in the last of those cycles, and `call_req` is low in the cycle after it. The in-service bit is therefore set 5 edges after the request was first sampled.
- R4: When high-level (priority bit 1) and low-level (priority bit 0) requests are pending together, the high-level source is called.
- R5: Among pending requests of the same level, the lowest source index is called.
- R6: A source whose enable bit is 0 is never called, and no source is called while `glb_en` is 0.
- R7: A high-level request is called while a low-level routine is in service (`in_svc` = 01).
- R8: No call starts while `in_svc[1]` is 1, and no low-level call starts while `in_svc[0]` is 1.
- R9: On the edge that ends a call, `in_svc[1]` is set for a high-level call and `in_svc[0]` for a low-level call.
- R10: A `ret_stb` cycle clears `in_svc[1]` if it is set, and otherwise clears `in_svc[0]`.
- R11: After a `ret_stb` cycle, no call starts until a later cycle with `insn_done` high has been seen, even with requests pending.
- R12: While `call_req` is high, `call_idx` does not change, even if the requests or priorities change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Level-sensitive request lines |
| irq_en | input | NSRC | Per-source enable |
| irq_pri | input | NSRC | Per-source level, 1 = high, 0 = low |
| glb_en | input | 1 | Global enable for all sources |
| ret_stb | input | 1 | One-cycle return-from-interrupt strobe |
| insn_done | input | 1 | One-cycle instruction-boundary strobe |
| call_req | output | 1 | Vector call in progress |
| call_idx | output | IDXW | Source index of the call in progress |
| call_taken | output | 1 | Last cycle of the call; the level becomes active |
| in_svc | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
A corrupted in-service bit shows at the ports within one cycle, because `in_svc` is an output. Its effect on arbitration shows at the next decision: either a preemption that should have been refused, or a call that should have been issued and is missing. A stale return-hold flag shows as a `call_req` rising one cycle early or never rising after a return. A wrong call counter shows as a `call_taken` pulse in the wrong cycle of the call. The bench's reference model compares every output on every clock, so each of these is caught in the cycle it first appears.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
    localparam int unsigned NLVL   = 2;
    localparam int unsigned LVL_LO = 0;
    localparam int unsigned LVL_HI = 1;
endpackage

// File: rtl/irqn_sample.sv
module irqn_sample #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic            glb_en,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] pend_d;

    always_comb begin
        pend_d = irq_req & irq_en & {NSRC{glb_en}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/irqn_pick.sv
module irqn_pick #(
    parameter int NSRC = 8,
    parameter int IDXW = 3
) (
    input  logic [NSRC-1:0] vec,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irqn_pkg::*;
#(
    parameter  int NSRC     = 8,
    parameter  int CALL_CYC = 4,
    localparam int IDXW     = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CNTW     = $clog2(CALL_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] irq_pri,
    input  logic            glb_en,
    input  logic            ret_stb,
    input  logic            insn_done,
    output logic            call_req,
    output logic [IDXW-1:0] call_idx,
    output logic            call_taken,
    output logic [1:0]      in_svc
);
    typedef struct packed {
        logic            busy;
        logic            hi;
        logic [IDXW-1:0] idx;
        logic [CNTW-1:0] cnt;
        logic [NLVL-1:0] isr;
        logic            hold;
    } ctl_t;

    ctl_t                      st_q, st_d;
    logic [NSRC-1:0]           pend;
    logic [NLVL-1:0]           lvl_any;
    logic [NLVL-1:0][IDXW-1:0] lvl_idx;
    logic                      taken, hi_ok, lo_ok, launch;

    irqn_sample #(.NSRC(NSRC)) u_sample (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .glb_en  (glb_en),
        .pend_q  (pend)
    );

    for (genvar gl = 0; gl < NLVL; gl++) begin : g_lvl
        logic [NSRC-1:0] lvl_mask;
        assign lvl_mask = (gl == LVL_HI) ? (pend & irq_pri) : (pend & ~irq_pri);
        irqn_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
            .vec (lvl_mask),
            .any (lvl_any[gl]),
            .idx (lvl_idx[gl])
        );
    end

    always_comb begin
        st_d   = st_q;
        taken  = st_q.busy && (st_q.cnt == CNTW'(CALL_CYC - 1));
        hi_ok  = lvl_any[LVL_HI] && !st_q.isr[LVL_HI];
        lo_ok  = lvl_any[LVL_LO] && (st_q.isr == '0);
        launch = !st_q.busy && !st_q.hold && !ret_stb && (hi_ok || lo_ok);

        if (st_q.busy) begin
            if (taken) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end

        if (launch) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.hi   = hi_ok;
            st_d.idx  = hi_ok ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
        end

        if (ret_stb) begin
            if (st_q.isr[LVL_HI]) st_d.isr[LVL_HI] = 1'b0;
            else                  st_d.isr[LVL_LO] = 1'b0;
        end

        if (taken) begin
            if (st_q.hi) st_d.isr[LVL_HI] = 1'b1;
            else         st_d.isr[LVL_LO] = 1'b1;
        end

        if (ret_stb)        st_d.hold = 1'b1;
        else if (insn_done) st_d.hold = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign call_req   = st_q.busy;
    assign call_idx   = st_q.idx;
    assign call_taken = taken;
    assign in_svc     = st_q.isr;
endmodule

// File: rtl/irqn_chk.sv
module irqn_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_stb,
    input logic            call_req,
    input logic [IDXW-1:0] call_idx,
    input logic            call_taken,
    input logic [1:0]      in_svc
);
    AST_TAKEN_IN_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        call_taken |-> call_req);                                     // R3
    AST_CALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        call_taken |=> !call_req);                                    // R3
    AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && !call_taken |=> call_req && $stable(call_idx));   // R12
    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        call_taken && !ret_stb |=> in_svc != 2'b00);                  // R9
    AST_RET_HI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb && !call_taken && in_svc[1] |=> !in_svc[1]);          // R10
    AST_RET_LO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb && !call_taken && in_svc == 2'b01 |=> in_svc == 2'b00); // R10
    AST_NO_PREEMPT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |=> !$rose(call_req));                              // R8
    AST_RET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb |=> !$rose(call_req));                                // R11
endmodule

bind irq_nest_ctrl irqn_chk #(.IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_stb    (ret_stb),
    .call_req   (call_req),
    .call_idx   (call_idx),
    .call_taken (call_taken),
    .in_svc     (in_svc)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
    localparam int NSRC     = 8;
    localparam int CALL_CYC = 4;
    localparam int IDXW     = $clog2(NSRC);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0, irq_en = '1, irq_pri = '0;
    logic            glb_en = 1'b1, ret_stb = 1'b0, insn_done = 1'b0;
    logic            call_req, call_taken;
    logic [IDXW-1:0] call_idx;
    logic [1:0]      in_svc;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit              m_busy, m_hi, m_isr0, m_isr1, m_hold;
    int              m_cnt, m_idx;
    bit [NSRC-1:0]   m_pend;

    always #4 clk = ~clk;  // 125 MHz

    irq_nest_ctrl #(.NSRC(NSRC), .CALL_CYC(CALL_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .irq_pri(irq_pri), .glb_en(glb_en), .ret_stb(ret_stb),
        .insn_done(insn_done), .call_req(call_req), .call_idx(call_idx),
        .call_taken(call_taken), .in_svc(in_svc)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_hi = 0; m_isr0 = 0; m_isr1 = 0; m_hold = 0;
        m_cnt = 0; m_idx = 0; m_pend = '0;
    endtask

    task automatic model_step();
        bit tk, hi_ok, lo_ok, launch;
        int hi_i, lo_i;
        tk = m_busy && (m_cnt == CALL_CYC - 1);
        hi_i = -1; lo_i = -1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m_pend[i]) begin
                if (irq_pri[i]) hi_i = i;
                else            lo_i = i;
            end
        end
        hi_ok  = (hi_i >= 0) && !m_isr1;
        lo_ok  = (lo_i >= 0) && !m_isr1 && !m_isr0;
        launch = !m_busy && !m_hold && !ret_stb && (hi_ok || lo_ok);
        if (m_busy) begin
            if (tk) begin m_busy = 0; m_cnt = 0; end
            else    m_cnt++;
        end
        if (launch) begin
            m_busy = 1; m_cnt = 0; m_hi = hi_ok;
            m_idx = hi_ok ? hi_i : lo_i;
        end
        if (ret_stb) begin
            if (m_isr1) m_isr1 = 0;
            else        m_isr0 = 0;
        end
        if (tk) begin
            if (m_hi) m_isr1 = 1;
            else      m_isr0 = 1;
        end
        if (ret_stb)        m_hold = 1;
        else if (insn_done) m_hold = 0;
        m_pend = glb_en ? (irq_req & irq_en) : '0;
    endtask

    // one clock: model advances on the edge, outputs compared 2 ns later
    task automatic cyc();
        bit m_tk;
        @(posedge clk);
        if (!rst_n) model_reset();
        else        model_step();
        #2;
        m_tk = m_busy && (m_cnt == CALL_CYC - 1);
        check(call_req === m_busy, "R3 model call_req", call_req, m_busy);
        check(call_taken === m_tk, "R3 model call_taken", call_taken, m_tk);
        check(in_svc === {m_isr1, m_isr0}, "R9 model in_svc", in_svc, {m_isr1, m_isr0});
        if (m_busy)
            check(call_idx === IDXW'(m_idx), "R12 model call_idx", call_idx, m_idx);
    endtask

    task automatic wait_call(input string tag, input int exp_idx);
        bit seen = 0;
        for (int n = 0; n < 12 && !seen; n++) begin
            cyc();
            seen = call_req;
        end
        check(seen, {tag, " call raised"}, seen, 1);
        check(call_idx === IDXW'(exp_idx), {tag, " call index"}, call_idx, exp_idx);
    endtask

    task automatic wait_taken();
        bit seen = 0;
        for (int n = 0; n < 12 && !seen; n++) begin
            cyc();
            seen = call_taken;
        end
        check(seen, "R3 call_taken seen", seen, 1);
        cyc();
    endtask

    task automatic quiet(input string tag, input int n);
        bit any = 0;
        for (int k = 0; k < n; k++) begin
            cyc();
            any |= call_req;
        end
        check(!any, {tag, " no call issued"}, any, 0);
    endtask

    task automatic ret_seq();
        ret_stb = 1; cyc(); ret_stb = 0;
        cyc();
        insn_done = 1; cyc(); insn_done = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired act=1 exp=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) cyc();
        check(call_req === 0 && call_taken === 0, "R1 reset call outputs", call_req, 0);
        check(in_svc === 2'b00, "R1 reset in_svc", in_svc, 0);
        rst_n = 1;
        cyc();

        // fastest path: request sampled at edge k
        irq_req[3] = 1;
        cyc();
        check(call_req === 0, "R2 no call at sampling edge", call_req, 0);
        cyc();
        check(call_req === 1, "R2 call after detection cycle", call_req, 1);
        check(call_idx === 3, "R2 call index", call_idx, 3);
        cyc(); cyc();
        check(call_taken === 0, "R3 taken not early", call_taken, 0);
        cyc();
        check(call_taken === 1, "R3 taken in fourth call cycle", call_taken, 1);
        irq_req[3] = 0;
        cyc();
        check(call_req === 0, "R3 call dropped after taken", call_req, 0);
        check(in_svc === 2'b01, "R9 low level set at edge k+5", in_svc, 1);

        // preemption of a low routine
        irq_req[1] = 1;
        irq_pri[5] = 1; irq_req[5] = 1;
        wait_call("R7", 5);
        wait_taken();
        irq_req[5] = 0;
        check(in_svc === 2'b11, "R9 high level set", in_svc, 3);

        irq_pri[6] = 1; irq_req[6] = 1;
        quiet("R8 high in service", 8);

        ret_stb = 1; cyc(); ret_stb = 0;
        check(in_svc === 2'b01, "R10 return clears high first", in_svc, 1);
        quiet("R11 hold until boundary", 6);
        insn_done = 1; cyc(); insn_done = 0;
        check(call_req === 0, "R11 no call on boundary edge", call_req, 0);
        wait_call("R11", 6);
        wait_taken();
        irq_req[6] = 0;
        ret_stb = 1; cyc(); ret_stb = 0;
        check(in_svc === 2'b01, "R10 second high return", in_svc, 1);
        insn_done = 1; cyc(); insn_done = 0;
        quiet("R8 low held by low", 4);
        ret_stb = 1; cyc(); ret_stb = 0;
        check(in_svc === 2'b00, "R10 return clears low", in_svc, 0);
        insn_done = 1; cyc(); insn_done = 0;
        wait_call("R8", 1);
        wait_taken();
        irq_req[1] = 0;
        ret_seq();

        // same-level order, then index stability during the call
        irq_pri = '0;
        irq_req = 8'b1001_0100;
        wait_call("R5", 2);
        irq_req = 8'b0000_0001; irq_pri[0] = 1;
        begin
            bit seen = 0;
            for (int n = 0; n < 8 && !seen; n++) begin
                cyc();
                seen = call_taken;
                if (call_req)
                    check(call_idx === 2, "R12 index held during call", call_idx, 2);
            end
            check(seen, "R12 call completed", seen, 1);
        end
        cyc();
        check(in_svc === 2'b01, "R9 low set", in_svc, 1);
        wait_call("R7", 0);
        wait_taken();
        irq_req = '0;
        ret_seq();
        ret_seq();
        check(in_svc === 2'b00, "R10 both levels returned", in_svc, 0);

        // simultaneous high and low
        irq_pri = 8'b1000_0000;
        irq_req = 8'b1000_0001;
        wait_call("R4", 7);
        wait_taken();
        irq_req = '0;
        check(in_svc === 2'b10, "R9 high from idle", in_svc, 2);
        ret_seq();

        // enables
        irq_pri = '0;
        irq_en[0] = 0; irq_req = 8'b0000_0001;
        quiet("R6 source disabled", 8);
        irq_en = '1; glb_en = 0; irq_req = 8'b0000_0101;
        quiet("R6 global disabled", 8);
        glb_en = 1;
        wait_call("R6", 0);
        wait_taken();
        irq_req = '0;
        ret_seq();
        repeat (4) cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule